// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pulldown Control and Serial Output Takeover

This block is a CPU-addressed port of up to eight bidirectional pins. Three registers control each pin: a latch for the output value, a direction bit, and a bit that inhibits the pin's pulldown. For every pin the block drives four pad signals: output value, output enable, pulldown enable, and an input level. The input level passes through a synchronizer and then goes to the CPU read path.

One pin, chosen by parameter, can be claimed by an external serial peripheral. While the peripheral enable is high, that pin's output buffer is on and carries the peripheral's serial data, and its pulldown is off. The CPU can still read and write that pin's latch and direction bits, but those writes do not reach the pad until the peripheral lets go of the pin.

Register map, by offset on the address bus: 0 is the port data (write sets the latch, read is per-pin), 1 is the direction register (1 = output), and 2 is the pulldown-inhibit register (write-only). Offset 2 and every other offset read as zero.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset, all latch, direction and pulldown-inhibit bits are 0. Every pad_oe bit is 0, every pad_pd_en bit is 1, and a read of offset 1 returns 0.
- R2: A pin whose direction bit is 1, and which is not overridden, has pad_oe=1, pad_out equal to its latch bit, and pad_pd_en=0.
- R3: A pin whose direction bit is 0, and which is not overridden, has pad_oe=0. Its pad_pd_en is 1 exactly when its pulldown-inhibit bit is 0.
- R4: A read of offset 0 returns, for each pin, the latch bit if the direction bit is 1 and the synchronized pad level if it is 0.
- R5: A write to offset 0 updates the latch whatever the direction. A pin that later becomes an output drives the most recently written value.
- R6: The direction register at offset 1 reads back the last value written, whether per_en is high or low.
- R7: The pulldown-inhibit register at offset 2 takes writes but reads as zero. Offset 3 also reads as zero.
- R8: While per_en=1, the override pin has pad_oe=1, pad_out=per_sdo and pad_pd_en=0.
- R9: While per_en=1, writes to the override pin's latch or direction bit change none of its pad signals. They are still stored and read back.
- R10: While per_en=1 and the override pin's direction bit is 0, a read of offset 0 returns that pin's actual synchronized pad level.
- R11: A change on pad_in shows up in offset-0 reads two rising clock edges after it is sampled, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |
| pad_pd_en | output | WIDTH | Pad pulldown enables |
| per_en | input | 1 | Serial peripheral claims the override pin |
| per_sdo | input | 1 | Serial data driven onto the override pin |

## Verification
The bench targets direction changes made after data writes. A design that gated the latch write on direction would drive a stale value. It also targets direction and data writes made while the peripheral holds the override pin. A design that let those writes through would glitch the serial line or turn on the pulldown under a driven pin. Reads of the override pin while it is held and its direction is input must return the pad level, not the latch. Reads in the first and second cycles after a pad change expose a synchronizer that is too short or too long. Reads of the inhibit register expose a design that leaks its contents.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_DIR  = 1;
   localparam int unsigned OFS_PDI  = 2;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_PDI  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pd_regs.sv
module gpio_pd_regs
   import gpio_pd_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   output reg_sel_e          sel,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  pdi_q
);
   always_comb begin
      if (bus_addr == ADDR_W'(OFS_DATA))      sel = SEL_DATA;
      else if (bus_addr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
      else if (bus_addr == ADDR_W'(OFS_PDI))  sel = SEL_PDI;
      else                                    sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         pdi_q  <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_DATA: data_q <= bus_wdata;
            SEL_DIR:  dir_q  <= bus_wdata;
            SEL_PDI:  pdi_q  <= bus_wdata;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_pd_padctl.sv
module gpio_pd_padctl #(
   parameter int unsigned WIDTH   = 8,
   parameter bit          OVR_EN  = 1'b1,
   parameter int unsigned OVR_PIN = 5
) (
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pdi_q,
   input  logic             per_en,
   input  logic             per_sdo,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pd_en,
   output logic [WIDTH-1:0] held
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      if (OVR_EN && (i == OVR_PIN)) begin : g_ovr
         assign held[i]      = per_en;
         assign pad_oe[i]    = per_en | dir_q[i];
         assign pad_out[i]   = per_en ? per_sdo : data_q[i];
         assign pad_pd_en[i] = ~per_en & ~dir_q[i] & ~pdi_q[i];
      end else begin : g_plain
         assign held[i]      = 1'b0;
         assign pad_oe[i]    = dir_q[i];
         assign pad_out[i]   = data_q[i];
         assign pad_pd_en[i] = ~dir_q[i] & ~pdi_q[i];
      end
   end
endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
   import gpio_pd_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OVR_EN      = 1'b1,
   parameter int unsigned OVR_PIN     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_pd_en,
   input  logic              per_en,
   input  logic              per_sdo
);
   if (WIDTH < 1 || WIDTH > 8) begin : g_bad_width
      $error("gpio_pd_port: WIDTH must be 1..8");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("gpio_pd_port: ADDR_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pd_port: SYNC_STAGES must be at least 2");
   end
   if (OVR_EN && OVR_PIN >= WIDTH) begin : g_bad_ovr
      $error("gpio_pd_port: OVR_PIN outside port");
   end

   reg_sel_e         sel;
   logic [WIDTH-1:0] data_q, dir_q, pdi_q, pin_sync, held;

   gpio_pd_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .sel(sel), .data_q(data_q), .dir_q(dir_q),
      .pdi_q(pdi_q)
   );

   gpio_pd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   gpio_pd_padctl #(.WIDTH(WIDTH), .OVR_EN(OVR_EN), .OVR_PIN(OVR_PIN)) padctl_i (
      .data_q(data_q), .dir_q(dir_q), .pdi_q(pdi_q), .per_en(per_en),
      .per_sdo(per_sdo), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pd_en(pad_pd_en), .held(held)
   );

   // Port data read depends only on direction, never on the override state.
   always_comb begin
      unique case (sel)
         SEL_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_sync);
         SEL_DIR:  bus_rdata = dir_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_pd_chk.sv
module gpio_pd_chk #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned ADDR_W  = 2,
   parameter bit          OVR_EN  = 1'b1,
   parameter int unsigned OVR_PIN = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  pad_oe,
   input logic [WIDTH-1:0]  pad_pd_en,
   input logic [WIDTH-1:0]  data_q,
   input logic [WIDTH-1:0]  dir_q,
   input logic              per_en,
   input logic              per_sdo
);
   // R2, R8: a driven pad never has its pulldown on
   a_r2_no_pd_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pd_en) == '0);

   // R5: data writes always land in the latch
   a_r5_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(0)) |=> data_q == $past(bus_wdata));

   // R6: direction writes always land
   a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(1)) |=> bus_addr != ADDR_W'(1) || bus_rdata == $past(bus_wdata));

   // R7: inhibit register is write-only
   a_r7_pdi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'(2) |-> bus_rdata == '0);

   // R4: output pins read the latch
   a_r4_out_reads_latch: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'(0) |-> ((bus_rdata ^ data_q) & dir_q) == '0);

   if (OVR_EN) begin : g_ovr_chk
      // R8: override pin follows the peripheral
      a_r8_ovr_drive: assert property (@(posedge clk) disable iff (!rst_n)
         per_en |-> (pad_oe[OVR_PIN] && pad_out[OVR_PIN] == per_sdo && !pad_pd_en[OVR_PIN]));
      // R9: CPU writes do not disturb a held pin
      a_r9_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (per_en && $past(per_en) && $stable(per_sdo)) |-> $stable(pad_out[OVR_PIN]));
   end
endmodule

bind gpio_pd_port gpio_pd_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .OVR_EN(OVR_EN), .OVR_PIN(OVR_PIN)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
   .pad_oe(pad_oe), .pad_pd_en(pad_pd_en), .data_q(data_q), .dir_q(dir_q),
   .per_en(per_en), .per_sdo(per_sdo)
);

// File: tb/gpio_pd_port_tb_top.sv
`timescale 1ns/1ps
module gpio_pd_port_tb_top;
   localparam int OVP = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe, pad_pd_en;
   logic       per_en = 1'b0, per_sdo = 1'b0;

   always #4 clk = ~clk;

   gpio_pd_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd_en(pad_pd_en),
      .per_en(per_en), .per_sdo(per_sdo)
   );

   int vectors = 0, miscompares = 0;
   bit done = 0;
   logic [7:0] m_data = '0, m_dir = '0, m_pdi = '0;
   logic [7:0] hist[$];

   function automatic logic [7:0] synced();
      if (hist.size() >= 2) return hist[hist.size()-2];
      return '0;
   endfunction

   task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input string tag, input logic [1:0] a, input logic we,
                      input logic [7:0] wd, input logic [7:0] pin,
                      input logic pe, input logic sdo);
      logic [7:0] e_oe, e_out, e_pd, e_rd, sy;
      bus_addr = a; bus_we = we; bus_wdata = wd; pad_in = pin;
      per_en = pe; per_sdo = sdo;
      #1;
      e_oe = m_dir; e_out = m_data;
      if (pe) begin e_oe[OVP] = 1'b1; e_out[OVP] = sdo; end
      e_pd = ~e_oe & ~m_pdi;
      sy = synced();
      case (a)
         2'd0: for (int i = 0; i < 8; i++) e_rd[i] = m_dir[i] ? m_data[i] : sy[i];
         2'd1: e_rd = m_dir;
         default: e_rd = '0;
      endcase
      vectors++;
      cmp(tag, "pad_oe", pad_oe, e_oe);
      cmp(tag, "pad_out", pad_out, e_out);
      cmp(tag, "pad_pd_en", pad_pd_en, e_pd);
      cmp(tag, "bus_rdata", bus_rdata, e_rd);
      @(posedge clk);
      if (we) begin
         if (a == 2'd0) m_data = wd;
         else if (a == 2'd1) m_dir = wd;
         else if (a == 2'd2) m_pdi = wd;
      end
      hist.push_back(pin);
      if (hist.size() > 4) void'(hist.pop_front());
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      cyc("R1", 2'd1, 0, 8'h00, 8'h00, 0, 0);
      cyc("R1", 2'd0, 0, 8'h00, 8'h00, 0, 0);
      // R11 / R4: two-edge synchronizer latency
      cyc("R11", 2'd0, 0, 8'h00, 8'hA5, 0, 0);
      cyc("R11", 2'd0, 0, 8'h00, 8'hA5, 0, 0);
      cyc("R11", 2'd0, 0, 8'h00, 8'h5A, 0, 0);
      cyc("R11", 2'd0, 0, 8'h00, 8'h5A, 0, 0);
      cyc("R4", 2'd0, 0, 8'h00, 8'h5A, 0, 0);
      // R3: pulldown inhibit per pin
      cyc("R3", 2'd2, 1, 8'h0F, 8'h00, 0, 0);
      cyc("R3", 2'd0, 0, 8'h00, 8'h00, 0, 0);
      // R7: inhibit and spare offsets read zero
      cyc("R7", 2'd2, 0, 8'h00, 8'hFF, 0, 0);
      cyc("R7", 2'd3, 0, 8'h00, 8'hFF, 0, 0);
      // R5: latch written while input, then driven
      cyc("R5", 2'd0, 1, 8'h3C, 8'hC3, 0, 0);
      cyc("R5", 2'd0, 0, 8'h00, 8'hC3, 0, 0);
      cyc("R5", 2'd1, 1, 8'hFF, 8'hC3, 0, 0);
      cyc("R2", 2'd0, 0, 8'h00, 8'hC3, 0, 0);
      cyc("R6", 2'd1, 0, 8'h00, 8'hC3, 0, 0);
      // R4: mixed directions
      cyc("R4", 2'd1, 1, 8'h0F, 8'h55, 0, 0);
      cyc("R4", 2'd0, 0, 8'h00, 8'h55, 0, 0);
      cyc("R4", 2'd0, 0, 8'h00, 8'h55, 0, 0);
      // R8: peripheral takes override pin
      cyc("R8", 2'd0, 0, 8'h00, 8'h00, 1, 1);
      cyc("R8", 2'd0, 0, 8'h00, 8'h00, 1, 0);
      cyc("R8", 2'd0, 0, 8'h00, 8'h00, 1, 1);
      // R9: CPU writes to held pin
      cyc("R9", 2'd0, 1, 8'hFF, 8'h00, 1, 1);
      cyc("R9", 2'd1, 1, 8'hFF, 8'h00, 1, 1);
      cyc("R9", 2'd1, 1, 8'h00, 8'h00, 1, 0);
      cyc("R6", 2'd1, 0, 8'h00, 8'h00, 1, 0);
      // R10: held pin with direction 0 reads pad level
      cyc("R10", 2'd0, 0, 8'h00, 8'h20, 1, 0);
      cyc("R10", 2'd0, 0, 8'h00, 8'h20, 1, 0);
      cyc("R10", 2'd0, 0, 8'h00, 8'h00, 1, 1);
      cyc("R10", 2'd0, 0, 8'h00, 8'h00, 1, 1);
      cyc("R10", 2'd0, 0, 8'h00, 8'h00, 1, 1);
      // release: pin returns to latch/direction control
      cyc("R9", 2'd1, 1, 8'h20, 8'h00, 0, 1);
      cyc("R2", 2'd0, 0, 8'h00, 8'h00, 0, 1);
      // mixed random traffic
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r = $urandom;
         cyc("R4", r[1:0], r[2], r[15:8], r[23:16], r[24] & r[25], r[26]);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule